// File: doc/BRIEF.md
# Modem Line Status and Control Unit

This block is the modem-line part of a serial port controller. It takes the four active-low handshake pins (clear-to-send, data-set-ready, ring indicator, carrier detect) and passes them through a synchronizer. It then shows their asserted state in an 8-bit status word, next to sticky flags that record each change since software last read that word. A read strobe returns the word as it stands and clears the flags in the same cycle. A change that lands in the read cycle itself is kept.

The block also raises an interrupt request when a line change occurs and the modem interrupt is enabled. The request stays up until the status word is read or master reset is applied. A small control register holds three bits. The first drives the active-low terminal-ready output. The second puts the port in loopback, which forces terminal-ready inactive. The third turns on automatic clear-to-send flow control. In that mode, clear-to-send changes stop raising interrupts, and the clear-to-send level gates the transmitter through `tx_allow`.

Top module: `modem_stat_ctl`

## Requirements
- R1: `stat_q[4]`, `[5]`, `[6]` and `[7]` read 1 when `cts_n`, `dsr_n`, `ri_n` and `dcd_n` respectively are low. A pin change reaches these bits after SYNC_STAGES rising clock edges.
- R2: `stat_q[0]`, `[1]` and `[3]` set on the edge after any level change of clear-to-send, data-set-ready and carrier-detect respectively. They stay set until read.
- R3: `stat_q[2]` sets only when the ring indicator becomes asserted (`ri_n` goes high to low). A release of the ring indicator leaves it unchanged.
- R4: A cycle with `stat_rd` high clears `stat_q[3:0]` at the next edge. A change detected in that same cycle still sets its flag.
- R5: With `irq_en` high, a change event that sets any of the four change flags raises `irq` on the same edge.
- R6: While control bit 2 (automatic clear-to-send) is 1, a clear-to-send change still sets `stat_q[0]` but raises no interrupt. `tx_allow` is then equal to the asserted state of clear-to-send. With the bit at 0, `tx_allow` is 1.
- R7: Once raised, `irq` stays high, even if `irq_en` falls, until an edge with `stat_rd` high and no new interrupt event.
- R8: Control bit 0 set and control bit 1 (loopback) clear drive `dtr_n` low. Any other combination drives it high. A write with `ctl_we` takes effect at the next edge.
- R9: Master reset clears the change flags, `irq` and all control bits, and drives `dtr_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| mst_rst | input | 1 | Master reset, active high, asynchronous |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control value: bit 0 terminal ready, bit 1 loopback, bit 2 automatic clear-to-send |
| irq_en | input | 1 | Modem-status interrupt enable |
| stat_rd | input | 1 | Status read strobe, clears change flags |
| stat_q | output | 8 | Status word: bits 7..4 line levels, bits 3..0 change flags |
| irq | output | 1 | Modem-status interrupt request |
| dtr_n | output | 1 | Terminal-ready output, active low |
| tx_allow | output | 1 | Transmitter permit under automatic clear-to-send |

## Verification
Every internal register shows on a port within one clock. A corrupted synchronizer or previous-level register shows up first as a wrong level bit. On the next edge it also appears as a spurious or missing change flag and interrupt. A wrong control register shows on `dtr_n` and `tx_allow` in the cycle after the write. A flag that is dropped when a read and a change coincide shows as a missing change bit in the following cycle. The bench therefore compares every output on every clock against a behavioural model, with read strobes placed at each offset from a pin change.

// File: rtl/modem_stat_pkg.sv
package modem_stat_pkg;

   localparam int LINE_N  = 4;
   localparam int LN_CTS  = 0;
   localparam int LN_DSR  = 1;
   localparam int LN_RI   = 2;
   localparam int LN_DCD  = 3;
   localparam int CTL_W   = 3;

   typedef struct packed {
      logic auto_cts;
      logic loop_en;
      logic term_rdy;
   } mctl_t;

endpackage

// File: rtl/msc_sync.sv
module msc_sync #(
   parameter int               WIDTH   = 4,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("msc_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("msc_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
      end else begin
         stg_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/msc_detect.sv
module msc_detect #(
   parameter int               WIDTH     = 4,
   parameter logic [WIDTH-1:0] RISE_ONLY = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] lvl,
   input  logic             clr_rd,
   output logic [WIDTH-1:0] chg,
   output logic [WIDTH-1:0] delta
);

   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] delta_q;

   for (genvar g = 0; g < WIDTH; g++) begin : g_edge
      if (RISE_ONLY[g]) begin : g_rise
         assign chg[g] = lvl[g] & ~prev_q[g];
      end else begin : g_any
         assign chg[g] = lvl[g] ^ prev_q[g];
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         prev_q  <= '0;
         delta_q <= '0;
      end else begin
         prev_q  <= lvl;
         delta_q <= (clr_rd ? '0 : delta_q) | chg;
      end
   end

   assign delta = delta_q;

   AST_DELTA_CLR_ON_READ: assert property (@(posedge clk) disable iff (rst)
      (clr_rd && chg == '0) |=> (delta_q == '0)); // R4

   AST_DELTA_KEEPS_NEW: assert property (@(posedge clk) disable iff (rst)
      (chg != '0) |=> ((delta_q & $past(chg)) == $past(chg))); // R2

   AST_DELTA_STICKY: assert property (@(posedge clk) disable iff (rst)
      (!clr_rd) |=> ((delta_q & $past(delta_q)) == $past(delta_q))); // R2

endmodule

// File: rtl/msc_irq.sv
module msc_irq #(
   parameter int               WIDTH    = 4,
   parameter logic [WIDTH-1:0] SRC_MASK = '1,
   parameter int               GATE_BIT = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] chg,
   input  logic             irq_en,
   input  logic             gate_on,
   input  logic             clr_rd,
   output logic             irq
);

   if (GATE_BIT < 0 || GATE_BIT >= WIDTH) begin : g_bad_gate
      $error("msc_irq: GATE_BIT out of range");
   end

   localparam logic [WIDTH-1:0] GATE_ONEHOT = WIDTH'(1) << GATE_BIT;

   logic [WIDTH-1:0] src;
   logic             irq_q;

   assign src = chg & SRC_MASK & ~(gate_on ? GATE_ONEHOT : '0);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) irq_q <= 1'b0;
      else     irq_q <= (irq_en & (|src)) | (irq_q & ~clr_rd);
   end

   assign irq = irq_q;

   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
      (irq_q && !clr_rd) |=> irq_q); // R7

   AST_AUTOCTS_QUIET: assert property (@(posedge clk) disable iff (rst)
      (gate_on && !irq_q && (chg & ~GATE_ONEHOT) == '0) |=> !irq_q); // R6

   AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
      (irq_en && (chg & SRC_MASK & ~GATE_ONEHOT) != '0) |=> irq_q); // R5

endmodule

// File: rtl/msc_ctl.sv
module msc_ctl
   import modem_stat_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [CTL_W-1:0] wdata,
   input  logic             cts_lvl,
   output logic             dtr_n,
   output logic             loop_on,
   output logic             auto_on,
   output logic             tx_allow
);

   mctl_t ctl_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)     ctl_q <= '0;
      else if (we) ctl_q <= mctl_t'(wdata);
   end

   assign dtr_n    = ~(ctl_q.term_rdy & ~ctl_q.loop_en);
   assign loop_on  = ctl_q.loop_en;
   assign auto_on  = ctl_q.auto_cts;
   assign tx_allow = ~ctl_q.auto_cts | cts_lvl;

   AST_CTL_WRITE: assert property (@(posedge clk) disable iff (rst)
      we |=> (ctl_q == mctl_t'($past(wdata)))); // R8

endmodule

// File: rtl/modem_stat_ctl.sv
module modem_stat_ctl
   import modem_stat_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit RI_RISE     = 1'b1,
   parameter bit RI_IRQ      = 1'b1
) (
   input  logic             clk,
   input  logic             mst_rst,
   input  logic             cts_n,
   input  logic             dsr_n,
   input  logic             ri_n,
   input  logic             dcd_n,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic             irq_en,
   input  logic             stat_rd,
   output logic [7:0]       stat_q,
   output logic             irq,
   output logic             dtr_n,
   output logic             tx_allow
);

   localparam logic [LINE_N-1:0] RISE_MASK = LINE_N'(RI_RISE) << LN_RI;
   localparam logic [LINE_N-1:0] SRC_MASK  = ~(LINE_N'(!RI_IRQ) << LN_RI);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("modem_stat_ctl: SYNC_STAGES must be at least 2");
   end

   logic [LINE_N-1:0] pin_act;
   logic [LINE_N-1:0] lvl;
   logic [LINE_N-1:0] chg;
   logic [LINE_N-1:0] delta;
   logic              loop_on;
   logic              auto_on;

   assign pin_act = ~{dcd_n, ri_n, dsr_n, cts_n};

   msc_sync #(.WIDTH(LINE_N), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync (
      .clk (clk),
      .rst (mst_rst),
      .d   (pin_act),
      .q   (lvl)
   );

   msc_detect #(.WIDTH(LINE_N), .RISE_ONLY(RISE_MASK)) u_detect (
      .clk    (clk),
      .rst    (mst_rst),
      .lvl    (lvl),
      .clr_rd (stat_rd),
      .chg    (chg),
      .delta  (delta)
   );

   msc_irq #(.WIDTH(LINE_N), .SRC_MASK(SRC_MASK), .GATE_BIT(LN_CTS)) u_irq (
      .clk     (clk),
      .rst     (mst_rst),
      .chg     (chg),
      .irq_en  (irq_en),
      .gate_on (auto_on),
      .clr_rd  (stat_rd),
      .irq     (irq)
   );

   msc_ctl u_ctl (
      .clk      (clk),
      .rst      (mst_rst),
      .we       (ctl_we),
      .wdata    (ctl_wdata),
      .cts_lvl  (lvl[LN_CTS]),
      .dtr_n    (dtr_n),
      .loop_on  (loop_on),
      .auto_on  (auto_on),
      .tx_allow (tx_allow)
   );

   assign stat_q = {lvl, delta};

   AST_DTR_OFF_IN_LOOP: assert property (@(posedge clk) disable iff (mst_rst)
      loop_on |-> dtr_n); // R8

   AST_TX_FOLLOWS_CTS: assert property (@(posedge clk) disable iff (mst_rst)
      auto_on |-> (tx_allow == stat_q[4])); // R6

endmodule

// File: tb/modem_stat_ctl_bench.sv
module modem_stat_ctl_bench;

   logic       clk = 1'b0;
   logic       mst_rst = 1'b1;
   logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
   logic       ctl_we = 1'b0;
   logic [2:0] ctl_wdata = '0;
   logic       irq_en = 1'b0;
   logic       stat_rd = 1'b0;
   logic [7:0] stat_q;
   logic       irq, dtr_n, tx_allow;

   int    n_chk = 0;
   int    n_err = 0;
   bit    done  = 1'b0;
   string cur_req = "R9";

   always #4 clk = ~clk;

   modem_stat_ctl u_modem_stat_ctl (
      .clk(clk), .mst_rst(mst_rst), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
      .dcd_n(dcd_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .irq_en(irq_en),
      .stat_rd(stat_rd), .stat_q(stat_q), .irq(irq), .dtr_n(dtr_n),
      .tx_allow(tx_allow)
   );

   // Behavioural reference: line index 0 cts, 1 dsr, 2 ri, 3 dcd
   logic [3:0] m_s1 = '0, m_lvl = '0, m_prev = '0, m_delta = '0;
   logic [3:0] m_ch, m_src;
   logic       m_irq = 1'b0;
   logic [2:0] m_ctl = '0;

   always @(posedge clk) begin
      if (mst_rst) begin
         m_s1 = '0; m_lvl = '0; m_prev = '0; m_delta = '0; m_irq = 1'b0; m_ctl = '0;
      end else begin
         m_ch    = m_lvl ^ m_prev;
         m_ch[2] = m_lvl[2] & ~m_prev[2];
         m_src   = m_ch;
         if (m_ctl[2]) m_src[0] = 1'b0;
         m_irq   = (irq_en && m_src != 0) || (m_irq && !stat_rd);
         m_delta = (stat_rd ? 4'b0 : m_delta) | m_ch;
         m_prev  = m_lvl;
         m_lvl   = m_s1;
         m_s1    = ~{dcd_n, ri_n, dsr_n, cts_n};
         if (ctl_we) m_ctl = ctl_wdata;
      end
   end

   task automatic check(input string req, input string what, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         check(cur_req, "levels", int'(stat_q[7:4]), int'(m_lvl));
         check(cur_req, "change flags", int'(stat_q[3:0]), int'(m_delta));
         check(cur_req, "irq", int'(irq), int'(m_irq));
         check(cur_req, "dtr_n", int'(dtr_n), int'(!(m_ctl[0] && !m_ctl[1])));
         check(cur_req, "tx_allow", int'(tx_allow), int'(!m_ctl[2] || m_lvl[0]));
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #2;
      end
   endtask

   task automatic read_pulse();
      stat_rd = 1'b1; step(1); stat_rd = 1'b0;
   endtask

   task automatic write_ctl(input logic [2:0] v);
      ctl_wdata = v; ctl_we = 1'b1; step(1); ctl_we = 1'b0;
   endtask

   initial begin
      step(4);
      mst_rst = 1'b0;
      step(2);
      // R9: state after master reset
      check("R9", "flags after reset", int'(stat_q[3:0]), 0);
      check("R9", "irq after reset", int'(irq), 0);
      check("R9", "dtr_n after reset", int'(dtr_n), 1);

      // R8: terminal ready and loopback override
      cur_req = "R8";
      write_ctl(3'b001); step(1);
      check("R8", "dtr_n asserted", int'(dtr_n), 0);
      write_ctl(3'b011); step(1);
      check("R8", "dtr_n in loopback", int'(dtr_n), 1);
      write_ctl(3'b001); step(2);

      // R1 and R2: levels and change flags with interrupts off
      cur_req = "R1";
      cts_n = 1'b0; step(4);
      check("R1", "cts level bit", int'(stat_q[4]), 1);
      cur_req = "R2";
      check("R2", "cts change flag", int'(stat_q[0]), 1);
      dsr_n = 1'b0; step(4);
      dcd_n = 1'b0; step(4);
      check("R2", "dsr/dcd flags", int'(stat_q[3:0] & 4'b1010), 4'b1010);
      check("R1", "all levels", int'(stat_q[7:4]), 4'b1011);

      // R4: read clears
      cur_req = "R4";
      read_pulse(); step(1);
      check("R4", "flags cleared", int'(stat_q[3:0]), 0);

      // R3: ring indicator, assertion edge only
      cur_req = "R3";
      ri_n = 1'b0; step(4);
      check("R3", "ri assert flag", int'(stat_q[2]), 1);
      read_pulse(); step(1);
      ri_n = 1'b1; step(5);
      check("R3", "ri release no flag", int'(stat_q[2]), 0);

      // R5 and R7: interrupt raise and hold
      cur_req = "R5";
      irq_en = 1'b1;
      dsr_n = 1'b1; step(4);
      check("R5", "irq on dsr change", int'(irq), 1);
      cur_req = "R7";
      irq_en = 1'b0; step(6);
      check("R7", "irq held", int'(irq), 1);
      read_pulse(); step(1);
      check("R7", "irq cleared by read", int'(irq), 0);
      irq_en = 1'b1;
      ri_n = 1'b0; step(4); ri_n = 1'b1; step(4);
      read_pulse(); step(2);

      // R6: automatic clear-to-send
      cur_req = "R6";
      write_ctl(3'b101); step(1);
      cts_n = 1'b1; step(5);
      check("R6", "no irq for cts", int'(irq), 0);
      check("R6", "cts flag still set", int'(stat_q[0]), 1);
      check("R6", "tx blocked", int'(tx_allow), 0);
      cts_n = 1'b0; step(5);
      check("R6", "tx allowed", int'(tx_allow), 1);
      dcd_n = 1'b1; step(5);
      check("R6", "dcd still raises irq", int'(irq), 1);
      read_pulse(); step(1);
      write_ctl(3'b001); step(1);

      // R4: read placed at every offset from a pin change
      cur_req = "R4";
      for (int off = 0; off < 5; off++) begin
         dsr_n = ~dsr_n;
         step(off);
         read_pulse();
         step(4);
         read_pulse();
         step(1);
      end
      for (int off = 0; off < 5; off++) begin
         cts_n = ~cts_n; dcd_n = ~dcd_n;
         step(off);
         read_pulse();
         step(3);
      end
      read_pulse(); step(2);

      // R9: master reset mid-activity
      cur_req = "R9";
      dsr_n = ~dsr_n; step(3);
      mst_rst = 1'b1; step(2);
      mst_rst = 1'b0; step(1);
      check("R9", "flags after late reset", int'(stat_q[3:0]), 0);
      check("R9", "irq after late reset", int'(irq), 0);
      check("R9", "dtr_n after late reset", int'(dtr_n), 1);
      step(6);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule